// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the low address bits for each beat of a four-beat burst on a synchronous burst memory. An access starts when one of two active-low address strobes is sampled. One strobe belongs to the processor and the other to the memory controller. The start also needs the chip to be selected. At the start, the block captures the two low address bits it is given. After that, each sampled advance request moves the burst to its next beat. The beat address comes out in one of two orders, chosen by a static select level. Linear order wraps modulo four. Interleaved order XORs the start value with the beat index.

The chip-select qualification comes in two parts. One input is the first chip enable, which is active low. The other input reports that every remaining chip enable is active. The processor strobe is disregarded entirely while the first chip enable is high. When both strobes are sampled together and the processor strobe is eligible, the processor strobe is the one acted upon. A strobe that arrives while the chip is not selected ends the burst. The block does not decode upper address bits and does not touch the memory array.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `beat_addr`=0, `burst_live`=0 and `by_proc`=0. This reset overrides any strobe sampled at that edge.
- R2: The controller strobe starts a burst when it is low at an edge with `ce1_n`=0 and `sel_rest`=1, and the processor strobe is not acting at that edge. After that edge, `beat_addr` equals the sampled `low_addr`, `burst_live`=1 and `by_proc`=0.
- R3: The processor strobe starts a burst when it is low at an edge with `ce1_n`=0 and `sel_rest`=1. After that edge, `beat_addr` equals the sampled `low_addr`, `burst_live`=1 and `by_proc`=1.
- R4: A processor strobe sampled while `ce1_n`=1 has no effect. If the controller strobe is high at that edge, every output keeps its value.
- R5: When both strobes are low at an edge with `ce1_n`=0 and `sel_rest`=1, the processor strobe is the one acted upon, so `by_proc`=1 afterwards.
- R6: An acting strobe sampled while the chip is not selected ends the burst. The chip is not selected when `ce1_n`=1 (controller strobe only) or when `sel_rest`=0. Afterwards `burst_live`=0 and `by_proc`=0, and `beat_addr` keeps its value.
- R7: While `burst_live`=1, `adv_n` low at an edge with no strobe low moves the beat index from k to (k+1) mod 4.
- R8: With `order_sel`=0 (linear), `beat_addr` is (start + index) mod 4.
- R9: With `order_sel`=1 (interleaved), `beat_addr` is start XOR index.
- R10: An edge with `adv_n` high and no strobe low leaves every output unchanged. So does `adv_n` low while `burst_live`=0.
- R11: Four advances bring the beat index back to 0, so `beat_addr` returns to the start value.
- R12: A start and an advance sampled at the same edge resolve as the start, and the beat index restarts at 0. A deselect and an advance at the same edge resolve as the deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance request, active low |
| ce1_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| sel_rest | input | 1 | High when all remaining chip enables are active |
| low_addr | input | CNT_W | Starting low address bits |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; static level |
| beat_addr | output | CNT_W | Low address bits of the current beat |
| burst_live | output | 1 | A burst is selected and in progress |
| by_proc | output | 1 | The current burst was started by the processor strobe |

## Verification
A start and an advance can be sampled at the same edge, and so can a deselect and an advance. The table drives both strobes together with `adv_n` low while a burst is mid-sequence, and in another step it drives a proceeding strobe with an advance while the chip is deselected. In the start case the expected beat address is the freshly captured start, not the next beat. In the deselect case the expected beat address is the held value, with `burst_live` low. The checker also asserts that every start yields the sampled address on the following cycle, whatever the advance input did.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: burst length is 2**CNT_W beats, with CNT_W fixed at 2 by the top.
package burst_seq_pkg;

    // Burst order encoding, taken straight from the order select level
    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    // Action decided for the coming clock edge
    typedef enum logic [1:0] {
        ACT_HOLD     = 2'd0,
        ACT_ADVANCE  = 2'd1,
        ACT_LOAD     = 2'd2,
        ACT_DESELECT = 2'd3
    } seq_act_e;

endpackage

// File: rtl/burst_strobe_arb.sv
// Module: burst_strobe_arb
// Decides, from the two address strobes, the chip enables and the advance
// input, what the beat counter does at the next edge. The processor strobe
// counts only while the first chip enable is low. When it counts, it
// outranks the controller strobe. A counted strobe with the chip deselected
// ends the burst. Purely combinational.
module burst_strobe_arb
    import burst_seq_pkg::*;
(
    input  logic     proc_strobe_n,
    input  logic     ctrl_strobe_n,
    input  logic     adv_n,
    input  logic     ce1_n,
    input  logic     sel_rest,
    input  logic     live,
    output seq_act_e act,
    output logic     load_by_proc
);

    logic proc_take;
    logic ctrl_take;
    logic selected;

    // Qualify strobes: processor first, controller only when processor is idle
    always_comb begin
        proc_take = !proc_strobe_n && !ce1_n;
        ctrl_take = !ctrl_strobe_n && !proc_take;
        selected  = !ce1_n && sel_rest;
    end

    // Pick the action: strobes beat advance, advance beats hold
    always_comb begin
        act          = ACT_HOLD;
        load_by_proc = 1'b0;
        if (proc_take || ctrl_take) begin
            act          = selected ? ACT_LOAD : ACT_DESELECT;
            load_by_proc = proc_take && selected;
        end else if (live && !adv_n) begin
            act = ACT_ADVANCE;
        end
    end

endmodule

// File: rtl/burst_beat_cnt.sv
// Module: burst_beat_cnt
// Holds the captured start bits, the wrapping beat index, the live flag and
// the start-source flag. Assumes the action input is already arbitrated.
// Synchronous active-low reset.
module burst_beat_cnt
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_act_e         act,
    input  logic             load_by_proc,
    input  logic [CNT_W-1:0] low_addr,
    output logic [CNT_W-1:0] start_q,
    output logic [CNT_W-1:0] idx_q,
    output logic             live_q,
    output logic             by_proc_q
);

    localparam logic [CNT_W-1:0] IDX_ONE = CNT_W'(1);

    // Update the burst state once per edge according to the action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= '0;
            idx_q     <= '0;
            live_q    <= 1'b0;
            by_proc_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    start_q   <= low_addr;
                    idx_q     <= '0;
                    live_q    <= 1'b1;
                    by_proc_q <= load_by_proc;
                end
                ACT_ADVANCE: idx_q <= idx_q + IDX_ONE;
                ACT_DESELECT: begin
                    live_q    <= 1'b0;
                    by_proc_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps start bits and beat index to the beat address. Linear order adds with
// wraparound, and interleaved order XORs bit by bit. Assumes the order select
// is a static level, so it is used without synchronisation. Combinational.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] idx,
    input  logic             order_sel,
    output logic [CNT_W-1:0] beat_addr
);

    logic [CNT_W-1:0] lin_addr;
    logic [CNT_W-1:0] ilv_addr;

    // Interleaved sequence, one XOR per address bit
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_addr[b] = start[b] ^ idx[b];
    end

    // Linear sequence and final order selection
    always_comb begin
        lin_addr  = start + idx;
        beat_addr = (burst_order_e'(order_sel) == ORDER_INTERLEAVE) ? ilv_addr : lin_addr;
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Two-bit wraparound burst address sequencer with prioritised processor and
// controller strobes and a selectable linear or interleaved order. Assumes
// sel_rest already combines every chip enable other than the first.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             sel_rest,
    input  logic [CNT_W-1:0] low_addr,
    input  logic             order_sel,
    output logic [CNT_W-1:0] beat_addr,
    output logic             burst_live,
    output logic             by_proc
);

    seq_act_e         act;
    logic             load_by_proc;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] idx_q;

    burst_strobe_arb i_arb (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .ce1_n         (ce1_n),
        .sel_rest      (sel_rest),
        .live          (burst_live),
        .act           (act),
        .load_by_proc  (load_by_proc)
    );

    burst_beat_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .act          (act),
        .load_by_proc (load_by_proc),
        .low_addr     (low_addr),
        .start_q      (start_q),
        .idx_q        (idx_q),
        .live_q       (burst_live),
        .by_proc_q    (by_proc)
    );

    burst_order_map #(.CNT_W(CNT_W)) i_map (
        .start     (start_q),
        .idx       (idx_q),
        .order_sel (order_sel),
        .beat_addr (beat_addr)
    );

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Port-level temporal checks for burst_addr_seq, attached with bind.
module burst_addr_seq_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             proc_strobe_n,
    input logic             ctrl_strobe_n,
    input logic             adv_n,
    input logic             ce1_n,
    input logic             sel_rest,
    input logic [CNT_W-1:0] low_addr,
    input logic             order_sel,
    input logic [CNT_W-1:0] beat_addr,
    input logic             burst_live,
    input logic             by_proc
);

    // R2
    ctrl_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && proc_strobe_n && !ce1_n && sel_rest)
        |=> (burst_live && !by_proc && beat_addr == $past(low_addr)));

    // R3
    proc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !ce1_n && sel_rest)
        |=> (burst_live && by_proc && beat_addr == $past(low_addr)));

    // R4
    proc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && ce1_n && ctrl_strobe_n)
        |=> ($stable(burst_live) && $stable(by_proc)));

    // R6
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((!proc_strobe_n && !ce1_n) || !ctrl_strobe_n) && (ce1_n || !sel_rest))
        |=> (!burst_live && !by_proc));

    // R7
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_live && !adv_n && proc_strobe_n && ctrl_strobe_n && !order_sel)
        |=> (order_sel || beat_addr == CNT_W'($past(beat_addr) + CNT_W'(1))));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_n && proc_strobe_n && ctrl_strobe_n)
        |=> ($stable(burst_live) && $stable(by_proc)
             && (order_sel != $past(order_sel) || $stable(beat_addr))));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.CNT_W(CNT_W)) i_burst_addr_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .ce1_n         (ce1_n),
    .sel_rest      (sel_rest),
    .low_addr      (low_addr),
    .order_sel     (order_sel),
    .beat_addr     (beat_addr),
    .burst_live    (burst_live),
    .by_proc       (by_proc)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 20;
    localparam int WDOG_LIMIT = 5000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       proc_strobe_n, ctrl_strobe_n, adv_n, ce1_n, sel_rest, order_sel;
    logic [1:0] low_addr;
    logic [1:0] beat_addr;
    logic       burst_live, by_proc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Vector layout: {proc_n, ctrl_n, adv_n, ce1_n, sel_rest, low_addr[1:0],
    //                 order_sel, exp_addr[1:0], exp_live, exp_by_proc}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b1_0_1_0_1_10_0_10_1_0, // 0  R2 controller start at 2
        12'b1_1_0_0_1_00_0_11_1_0, // 1  R7 R8 linear step
        12'b1_1_0_0_1_00_0_00_1_0, // 2  R8 wrap modulo 4
        12'b1_1_1_0_1_00_0_00_1_0, // 3  R10 hold with adv high
        12'b1_1_0_0_1_00_0_01_1_0, // 4  R7 step
        12'b1_1_0_0_1_00_0_10_1_0, // 5  R11 back to start
        12'b0_1_1_0_1_01_1_01_1_1, // 6  R3 processor start at 1, interleaved
        12'b1_1_0_0_1_00_1_00_1_1, // 7  R9 1^1
        12'b1_1_0_0_1_00_1_11_1_1, // 8  R9 1^2
        12'b1_1_0_0_1_00_1_10_1_1, // 9  R9 1^3
        12'b0_0_0_0_1_11_1_11_1_1, // 10 R5 R12 both strobes plus advance
        12'b0_1_1_1_1_00_1_11_1_1, // 11 R4 gated processor strobe ignored
        12'b1_1_0_0_1_00_1_10_1_1, // 12 R9 3^1
        12'b0_0_0_1_1_00_1_10_0_0, // 13 R4 R6 R12 controller deselects
        12'b1_1_0_0_1_00_1_10_0_0, // 14 R10 advance while idle
        12'b1_0_1_0_1_01_0_01_1_0, // 15 R2 restart at 1
        12'b1_0_0_0_0_10_0_01_0_0, // 16 R6 deselect via sel_rest
        12'b0_1_0_0_1_00_0_00_1_1, // 17 R3 R12 start beats advance
        12'b1_1_0_0_1_00_0_01_1_1, // 18 R7 step
        12'b0_1_1_0_0_11_0_01_0_0  // 19 R6 processor strobe deselects
    };

    burst_addr_seq i_burst_addr_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .ce1_n         (ce1_n),
        .sel_rest      (sel_rest),
        .low_addr      (low_addr),
        .order_sel     (order_sel),
        .beat_addr     (beat_addr),
        .burst_live    (burst_live),
        .by_proc       (by_proc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic drive(input logic p, input logic c, input logic a,
                         input logic e, input logic s, input logic [1:0] la,
                         input logic o);
        proc_strobe_n = p; ctrl_strobe_n = c; adv_n = a;
        ce1_n = e; sel_rest = s; low_addr = la; order_sel = o;
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        n_chk++;
        if ({beat_addr, burst_live, by_proc} !== exp) begin
            n_fail++;
            $display("FAIL %s: actual addr/live/proc=%b expected=%b",
                     req, {beat_addr, burst_live, by_proc}, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1, 1, 1, 1, 0, 2'b00, 0);
        repeat (3) @(negedge clk);
        check("R1 reset state", 4'b00_0_0);
        rst_n = 1'b1;
        drive(VEC[0][11], VEC[0][10], VEC[0][9], VEC[0][8], VEC[0][7],
              VEC[0][6:5], VEC[0][4]);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            check($sformatf("table step %0d", i), VEC[i][3:0]);
            if (i + 1 < NVEC)
                drive(VEC[i+1][11], VEC[i+1][10], VEC[i+1][9], VEC[i+1][8],
                      VEC[i+1][7], VEC[i+1][6:5], VEC[i+1][4]);
        end
        // R9: interleaved from 2 gives 2,3,0,1
        drive(1, 0, 1, 0, 1, 2'b10, 1);
        @(negedge clk); check("R9 ilv beat0", 4'b10_1_0);
        drive(1, 1, 0, 0, 1, 2'b00, 1);
        @(negedge clk); check("R9 ilv beat1", 4'b11_1_0);
        @(negedge clk); check("R9 ilv beat2", 4'b00_1_0);
        @(negedge clk); check("R9 ilv beat3", 4'b01_1_0);
        @(negedge clk); check("R11 ilv wrap", 4'b10_1_0);
        // R8: linear from 3 gives 3,0,1,2
        drive(0, 1, 1, 0, 1, 2'b11, 0);
        @(negedge clk); check("R8 lin beat0", 4'b11_1_1);
        drive(1, 1, 0, 0, 1, 2'b00, 0);
        @(negedge clk); check("R8 lin beat1", 4'b00_1_1);
        @(negedge clk); check("R8 lin beat2", 4'b01_1_1);
        @(negedge clk); check("R8 lin beat3", 4'b10_1_1);
        @(negedge clk); check("R11 lin wrap", 4'b11_1_1);
        // R1: reset overrides a strobe at the same edge
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 1, 2'b11, 0);
        @(negedge clk); check("R1 reset beats strobe", 4'b00_0_0);
        rst_n = 1'b1;
        drive(1, 1, 1, 1, 0, 2'b00, 0);
        @(negedge clk); check("R10 idle after reset", 4'b00_0_0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual run still active expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule